// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This block rearranges the elements of one vector register under control of a per-element mask. In compress mode the elements whose mask bit is set are gathered, in ascending element order, into the lowest slots of the result, and the number of such elements comes back as the new vector length. Slots above that length are cleared. In expand mode the operation runs the other way. Source elements are taken in order from slot 0 upward and dropped into the positions whose mask bit is set. Positions with a clear mask bit keep the value of a separate merge vector.

A caller presents both vectors, the mask and the mode together with a one-cycle start strobe. One clock later the unit raises a one-cycle valid flag. The result and the count sit in registers, which are written only on a start, so they stay readable until the next operation. Element i of every vector bus occupies bits [i*ELEM_W +: ELEM_W].

Top module: `vec_pack_unit`

## Requirements
- R1: With mode_i = 0 (compress), result slot k holds the source element at the position of the k-th set mask bit, counting set bits from bit 0 upward. For example, mask 8'b1011_0010 puts elements 1, 4, 5 and 7 into slots 0 to 3.
- R2: In compress mode, every result slot at or above the packed count is zero.
- R3: count_o equals the number of set bits in the mask of the operation that was started, in both modes.
- R4: With mode_i = 1 (expand), the position of the k-th set mask bit receives source element k.
- R5: In expand mode, every position whose mask bit is 0 takes the merge element at the same position.
- R6: valid_o is high in exactly the cycle after a cycle with start_i high, and low otherwise.
- R7: Without start_i, result_o and count_o keep their values whatever the other inputs do.
- R8: While reset is active, and until the first operation, valid_o, result_o and count_o are all zero.
- R9: An all-zero mask gives a count of 0. Compress then returns all zeros, and expand returns the merge vector unchanged.
- R10: An all-ones mask gives a count of NUM_ELEM, and both modes return the source vector unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle strobe that launches an operation |
| mode_i | input | 1 | 0 = compress, 1 = expand |
| mask_i | input | NUM_ELEM | Per-element mask, bit i belongs to element i |
| src_i | input | NUM_ELEM*ELEM_W | Source vector |
| merge_i | input | NUM_ELEM*ELEM_W | Merge vector, used for unselected positions in expand mode |
| valid_o | output | 1 | Result valid, high for one cycle |
| result_o | output | NUM_ELEM*ELEM_W | Packed or expanded vector |
| count_o | output | $clog2(NUM_ELEM+1) | Population count of the mask |

## Verification
Every result, the count and the valid flag are due exactly one clock edge after the edge that sees start_i high. The bench drives its inputs on falling edges, holds start_i for one cycle, and samples all three outputs on the next falling edge, which lies half a period after the edge that loaded them. It samples valid_o once more a cycle later to confirm the flag has dropped. The hold check changes the inputs with start_i low, waits several cycles, and compares against the values captured earlier.

// File: rtl/vpk_pkg.sv
package vpk_pkg;
  typedef enum logic {
    VPK_COMPRESS = 1'b0,
    VPK_EXPAND   = 1'b1
  } vpk_mode_e;
endpackage

// File: rtl/vpk_prefix.sv
// Exclusive running count of set mask bits below each position, plus total.
module vpk_prefix #(
  parameter int NUM_ELEM = 8,
  localparam int CNT_W = $clog2(NUM_ELEM + 1)
) (
  input  logic [NUM_ELEM-1:0]       mask_i,
  output logic [NUM_ELEM*CNT_W-1:0] rank_o,
  output logic [CNT_W-1:0]          total_o
);
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    rank_o = '0;
    for (int i = 0; i < NUM_ELEM; i++) begin
      rank_o[i*CNT_W +: CNT_W] = acc;
      acc = acc + CNT_W'(mask_i[i]);
    end
    total_o = acc;
  end
endmodule

// File: rtl/vpk_compress.sv
// Each destination slot ORs in the single source whose rank matches the slot.
module vpk_compress #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16,
  localparam int CNT_W = $clog2(NUM_ELEM + 1),
  localparam int VEC_W = NUM_ELEM * ELEM_W
) (
  input  logic [NUM_ELEM-1:0]       mask_i,
  input  logic [NUM_ELEM*CNT_W-1:0] rank_i,
  input  logic [VEC_W-1:0]          src_i,
  output logic [VEC_W-1:0]          packed_o
);
  for (genvar j = 0; j < NUM_ELEM; j++) begin : g_slot
    always_comb begin
      logic [ELEM_W-1:0] pick;
      pick = '0;
      for (int i = j; i < NUM_ELEM; i++) begin
        if (mask_i[i] && (rank_i[i*CNT_W +: CNT_W] == CNT_W'(j)))
          pick = pick | src_i[i*ELEM_W +: ELEM_W];
      end
      packed_o[j*ELEM_W +: ELEM_W] = pick;
    end
  end
endmodule

// File: rtl/vpk_expand.sv
// Each position selects source[rank] when its mask bit is set, else merge.
module vpk_expand #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16,
  localparam int CNT_W = $clog2(NUM_ELEM + 1),
  localparam int VEC_W = NUM_ELEM * ELEM_W
) (
  input  logic [NUM_ELEM-1:0]       mask_i,
  input  logic [NUM_ELEM*CNT_W-1:0] rank_i,
  input  logic [VEC_W-1:0]          src_i,
  input  logic [VEC_W-1:0]          merge_i,
  output logic [VEC_W-1:0]          spread_o
);
  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_pos
    always_comb begin
      logic [ELEM_W-1:0] pick;
      pick = '0;
      for (int k = 0; k <= i; k++) begin
        if (rank_i[i*CNT_W +: CNT_W] == CNT_W'(k))
          pick = src_i[k*ELEM_W +: ELEM_W];
      end
      spread_o[i*ELEM_W +: ELEM_W] = mask_i[i] ? pick : merge_i[i*ELEM_W +: ELEM_W];
    end
  end
endmodule

// File: rtl/vec_pack_unit.sv
module vec_pack_unit #(
  parameter int NUM_ELEM = 8,
  parameter int ELEM_W   = 16,
  localparam int CNT_W = $clog2(NUM_ELEM + 1),
  localparam int VEC_W = NUM_ELEM * ELEM_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [NUM_ELEM-1:0] mask_i,
  input  logic [VEC_W-1:0]    src_i,
  input  logic [VEC_W-1:0]    merge_i,
  output logic                valid_o,
  output logic [VEC_W-1:0]    result_o,
  output logic [CNT_W-1:0]    count_o
);
  import vpk_pkg::*;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // datapath
  logic [NUM_ELEM*CNT_W-1:0] rank;
  logic [CNT_W-1:0]          total;
  logic [VEC_W-1:0]          packed_v;
  logic [VEC_W-1:0]          spread_v;
  vpk_mode_e                 mode;

  assign mode = vpk_mode_e'(mode_i);

  vpk_prefix #(.NUM_ELEM(NUM_ELEM)) u_prefix (
    .mask_i (mask_i),
    .rank_o (rank),
    .total_o(total)
  );

  vpk_compress #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_compress (
    .mask_i  (mask_i),
    .rank_i  (rank),
    .src_i   (src_i),
    .packed_o(packed_v)
  );

  vpk_expand #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W)) u_expand (
    .mask_i  (mask_i),
    .rank_i  (rank),
    .src_i   (src_i),
    .merge_i (merge_i),
    .spread_o(spread_v)
  );

  // next state
  logic [VEC_W-1:0] res_d, res_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             vld_d, vld_q;
  logic             load_en;

  assign load_en = start_i;

  always_comb begin
    vld_d = start_i;
    res_d = res_q;
    cnt_d = cnt_q;
    if (load_en) begin
      res_d = (mode == VPK_EXPAND) ? spread_v : packed_v;
      cnt_d = total;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vld_q <= 1'b0;
      res_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      cnt_q <= cnt_d;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;
  assign count_o  = cnt_q;

  // assertions
  assert_valid_after_start_R6: assert property (
    @(posedge clk) disable iff (!rst_n_s) start_i |=> valid_o);

  assert_valid_idle_R6: assert property (
    @(posedge clk) disable iff (!rst_n_s) !start_i |=> !valid_o);

  assert_hold_R7: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    !start_i |=> ($stable(result_o) && $stable(count_o)));

  assert_count_popcount_R3: assert property (
    @(posedge clk) disable iff (!rst_n_s)
    start_i |=> (32'(count_o) == $past($countones(mask_i))));

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_chk
    assert_expand_merge_R5: assert property (
      @(posedge clk) disable iff (!rst_n_s)
      (start_i && mode_i && !mask_i[g]) |=>
        (result_o[g*ELEM_W +: ELEM_W] == $past(merge_i[g*ELEM_W +: ELEM_W])));

    assert_compress_tail_R2: assert property (
      @(posedge clk) disable iff (!rst_n_s)
      (start_i && !mode_i && ($countones(mask_i) <= g)) |=>
        (result_o[g*ELEM_W +: ELEM_W] == '0));
  end
endmodule

// File: tb/vec_pack_unit_test.sv
module vec_pack_unit_test;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int CW = $clog2(N + 1);
  localparam int VW = N * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [N-1:0]  mask_i = '0;
  logic [VW-1:0] src_i = '0;
  logic [VW-1:0] merge_i = '0;
  logic          valid_o;
  logic [VW-1:0] result_o;
  logic [CW-1:0] count_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  vec_pack_unit #(.NUM_ELEM(N), .ELEM_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .mask_i(mask_i), .src_i(src_i), .merge_i(merge_i),
    .valid_o(valid_o), .result_o(result_o), .count_o(count_o)
  );

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] ref_pack(input logic [N-1:0] m, input logic [VW-1:0] s);
    logic [VW-1:0] r;
    int k;
    r = '0;
    k = 0;
    for (int i = 0; i < N; i++)
      if (m[i]) begin
        r[k*W +: W] = s[i*W +: W];
        k++;
      end
    return r;
  endfunction

  function automatic logic [VW-1:0] ref_spread(input logic [N-1:0] m, input logic [VW-1:0] s,
                                                input logic [VW-1:0] mg);
    logic [VW-1:0] r;
    int k;
    r = mg;
    k = 0;
    for (int i = 0; i < N; i++)
      if (m[i]) begin
        r[i*W +: W] = s[k*W +: W];
        k++;
      end
    return r;
  endfunction

  function automatic int ones(input logic [N-1:0] m);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  // one operation: start on a falling edge, sample on the next one
  task automatic run_op(input logic md, input logic [N-1:0] m, input logic [VW-1:0] s,
                        input logic [VW-1:0] mg);
    @(negedge clk);
    mode_i = md; mask_i = m; src_i = s; merge_i = mg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic logic [VW-1:0] seq_vec(input logic [W-1:0] base);
    logic [VW-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = base + W'(i);
    return v;
  endfunction

  task automatic t_reset;
    chk("R8 valid in reset", VW'(valid_o), '0);
    chk("R8 result in reset", result_o, '0);
    chk("R8 count in reset", VW'(count_o), '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 valid after reset", VW'(valid_o), '0);
    chk("R8 result after reset", result_o, '0);
  endtask

  task automatic t_compress_example;
    logic [VW-1:0] a, e;
    a = seq_vec(16'hA000);
    run_op(1'b0, 8'b1011_0010, a, '0);
    e = '0;
    e[0*W +: W] = 16'hA001; e[1*W +: W] = 16'hA004;
    e[2*W +: W] = 16'hA005; e[3*W +: W] = 16'hA007;
    chk("R1 compress example", result_o, e);
    chk("R2 compress example tail", VW'(result_o[VW-1:4*W]), '0);
    chk("R3 compress example count", VW'(count_o), VW'(4));
    chk("R6 valid after start", VW'(valid_o), VW'(1));
    @(negedge clk);
    chk("R6 valid drops", VW'(valid_o), '0);
  endtask

  task automatic t_compress_patterns;
    logic [N-1:0] ms [6] = '{8'h01, 8'h80, 8'h5A, 8'hC3, 8'h7E, 8'h24};
    logic [VW-1:0] s;
    s = seq_vec(16'h1230);
    foreach (ms[p]) begin
      run_op(1'b0, ms[p], s, seq_vec(16'hFF00));
      chk("R1 R2 compress pattern", result_o, ref_pack(ms[p], s));
      chk("R3 compress count", VW'(count_o), VW'(ones(ms[p])));
    end
  endtask

  task automatic t_expand;
    logic [N-1:0] ms [5] = '{8'b1011_0010, 8'h01, 8'h80, 8'hA5, 8'h3C};
    logic [VW-1:0] s, mg;
    s = seq_vec(16'hA000);
    mg = seq_vec(16'hB000);
    foreach (ms[p]) begin
      run_op(1'b1, ms[p], s, mg);
      chk("R4 R5 expand pattern", result_o, ref_spread(ms[p], s, mg));
      chk("R3 expand count", VW'(count_o), VW'(ones(ms[p])));
    end
    // explicit: mask 0xB2 -> A0 at pos1, A1 at pos4, A2 at pos5, A3 at pos7
    run_op(1'b1, 8'b1011_0010, s, mg);
    chk("R4 expand pos1", VW'(result_o[1*W +: W]), VW'(16'hA000));
    chk("R4 expand pos7", VW'(result_o[7*W +: W]), VW'(16'hA003));
    chk("R5 expand pos0 merge", VW'(result_o[0*W +: W]), VW'(16'hB000));
  endtask

  task automatic t_zero_mask;
    run_op(1'b0, '0, seq_vec(16'h4000), seq_vec(16'h5000));
    chk("R9 zero mask compress", result_o, '0);
    chk("R9 zero mask count", VW'(count_o), '0);
    run_op(1'b1, '0, seq_vec(16'h4000), seq_vec(16'h5000));
    chk("R9 zero mask expand", result_o, seq_vec(16'h5000));
    chk("R9 zero mask expand count", VW'(count_o), '0);
  endtask

  task automatic t_full_mask;
    run_op(1'b0, '1, seq_vec(16'h6000), seq_vec(16'h7000));
    chk("R10 full mask compress", result_o, seq_vec(16'h6000));
    chk("R10 full mask count", VW'(count_o), VW'(N));
    run_op(1'b1, '1, seq_vec(16'h6000), seq_vec(16'h7000));
    chk("R10 full mask expand", result_o, seq_vec(16'h6000));
  endtask

  task automatic t_hold;
    logic [VW-1:0] keep_r;
    logic [CW-1:0] keep_c;
    run_op(1'b0, 8'h96, seq_vec(16'h2200), '0);
    keep_r = result_o;
    keep_c = count_o;
    mode_i = 1'b1; mask_i = 8'hFF; src_i = seq_vec(16'h9900); merge_i = seq_vec(16'h8800);
    repeat (4) @(negedge clk);
    chk("R7 hold result", result_o, keep_r);
    chk("R7 hold count", VW'(count_o), VW'(keep_c));
    chk("R6 no valid without start", VW'(valid_o), '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_compress_example();
    t_compress_patterns();
    t_expand();
    t_zero_mask();
    t_full_mask();
    t_hold();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule